// File: doc/BRIEF.md
# Two-Wire Four-Phase Test-Port Sequencer

This block is the host end of a test-access link that runs over two wires: one clock line driven by the host and one data line shared by both sides. Each test-port step carries three bits: a data-in bit, a mode-select bit, and a data-out bit returned by the target. The block sends each step as four clock pulses on the one wire. The first pulse carries the data-in bit outward. The second carries the mode-select bit outward. The host then releases the data wire. After the third pulse falls, the target answers on the data wire, and the host samples that answer during the low half of the third pulse. The fourth pulse completes the step.

A controller above this block presents one step at a time on a request/ready pair. It then waits for a single-cycle completion strobe, which comes with the returned bit. The lengths of the clock phases are counted in system clocks and set by parameters, so that the link can meet the minimum phase and period times of the target. A settle parameter places the data-out sample a few system clocks after the third falling edge, which allows for a slow data line, for example one with a series resistor and some line capacitance. The block also drives the target's reset line from a separate control input.

Top module: `twowire_jtag_host`

## Requirements
- R1: After reset, and whenever no step is in progress, `tck_o` is low, `tdat_oe` is low and `req_ready` is high.
- R2: A step consists of exactly four pulses on `tck_o`. Each pulse is high for HI_CYC system clocks and then low for LO_CYC system clocks, and the first high clock follows the accepting clock edge directly.
- R3: During the whole of the first pulse, `tdat_oe` is high and `tdat_o` equals the accepted data-in bit, so the target sees that bit at the first falling edge.
- R4: During the whole of the second pulse, `tdat_oe` is high and `tdat_o` equals the accepted mode-select bit.
- R5: `tdat_oe` is low from the rise of the third pulse until the end of the step, and it stays low while idle.
- R6: The returned bit is the value of `tdat_i` seen at the system-clock edge that closes low cycle number SETTLE_CYC of the third pulse. Low cycles are counted from 0 at the third falling edge, and SETTLE_CYC must be less than LO_CYC.
- R7: `done` is high for exactly one cycle, which starts 4*(HI_CYC+LO_CYC) clocks after the accepting edge. `done_tdo` holds the returned bit while `done` is high, and `req_ready` is high again in that same cycle.
- R8: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. While a step is in progress, `req_valid` and the request bits have no effect on the wire sequence or on the number of `done` strobes.
- R9: `tgt_rst_n` is low while the block is in reset. Otherwise it is the inverse of `tgt_rst_req`, delayed by one clock.
- R10: Whenever `tdat_oe` is low, `tdat_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A step request is present |
| req_tdi | input | 1 | Data-in bit for the step |
| req_tms | input | 1 | Mode-select bit for the step |
| req_ready | output | 1 | The engine is idle and will take a request |
| done | output | 1 | Single-cycle completion strobe |
| done_tdo | output | 1 | Returned data-out bit, valid with `done` |
| tck_o | output | 1 | Link clock line |
| tdat_o | output | 1 | Data line, value driven by the host |
| tdat_oe | output | 1 | Host drive enable for the data line |
| tdat_i | input | 1 | Data line, value seen at the pin |
| tgt_rst_req | input | 1 | Request to hold the target in reset |
| tgt_rst_n | output | 1 | Target reset line, active low |

## Verification
A wrong phase or pulse counter shows on `tck_o` within one phase: a high or low run has the wrong length, or a step has other than four pulses, and `done` then arrives on the wrong clock. A bad pulse index shows during the next pulse, because the enable stays on into the target's turn, or because the wrong bit, or a stale one, is on the data line at a falling edge. The bench drives `tdat_i` with the correct answer only in the single low cycle that R6 names. It drives the inverse in every other cycle, so a sample point that is off by one clock returns a wrong `done_tdo` on the very step where the error occurs.

// File: rtl/jtag2w_pkg.sv
package jtag2w_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [1:0] pulse;
        logic       bit_di;
        logic       bit_ms;
        logic       tck;
        logic       oe;
        logic       dout;
        logic       done;
    } seq_state_t;

endpackage

// File: rtl/jtag2w_phase_timer.sv
module jtag2w_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clear ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count   = cnt_q;
    assign at_last = (cnt_q == last_val);
endmodule

// File: rtl/jtag2w_capture.sv
module jtag2w_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic din,
    output logic dout
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = take ? din : bit_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign dout = bit_q;
endmodule

// File: rtl/jtag2w_rst_drv.sv
module jtag2w_rst_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    output logic line_n
);
    logic line_d, line_q;

    always_comb begin
        line_d = ~hold_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
    end

    assign line_n = line_q;
endmodule

// File: rtl/twowire_jtag_host.sv
module twowire_jtag_host
    import jtag2w_pkg::*;
#(
    parameter int HI_CYC     = 4,
    parameter int LO_CYC     = 6,
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_tdi,
    input  logic req_tms,
    output logic req_ready,
    output logic done,
    output logic done_tdo,
    output logic tck_o,
    output logic tdat_o,
    output logic tdat_oe,
    input  logic tdat_i,
    input  logic tgt_rst_req,
    output logic tgt_rst_n
);
    localparam int MAX_PH = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CNT_W  = $clog2(MAX_PH + 1);
    localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LAST  = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE_CYC);
    localparam logic [1:0]       LAST_PULSE = 2'd3;
    localparam logic [1:0]       ANS_PULSE  = 2'd2;

    seq_state_t       s_d, s_q;
    logic [CNT_W-1:0] ph_cnt;
    logic [CNT_W-1:0] ph_last_val;
    logic             ph_at_last;
    logic             ph_clear;
    logic             take_ans;

    assign ph_last_val = (s_q.ph == PH_HIGH) ? HI_LAST : LO_LAST;
    assign ph_clear    = (s_q.ph == PH_IDLE) || ph_at_last;
    assign take_ans    = (s_q.ph == PH_LOW) && (s_q.pulse == ANS_PULSE)
                         && (ph_cnt == SETTLE_C);

    jtag2w_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ph_clear),
        .last_val (ph_last_val),
        .count    (ph_cnt),
        .at_last  (ph_at_last)
    );

    jtag2w_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take_ans),
        .din   (tdat_i),
        .dout  (done_tdo)
    );

    jtag2w_rst_drv u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (tgt_rst_req),
        .line_n   (tgt_rst_n)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph     = PH_HIGH;
                    s_d.pulse  = 2'd0;
                    s_d.bit_di = req_tdi;
                    s_d.bit_ms = req_tms;
                end
            end
            PH_HIGH: begin
                if (ph_at_last) s_d.ph = PH_LOW;
            end
            PH_LOW: begin
                if (ph_at_last) begin
                    if (s_q.pulse == LAST_PULSE) begin
                        s_d.ph   = PH_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.ph    = PH_HIGH;
                        s_d.pulse = s_q.pulse + 2'd1;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        // pin values registered from the next state
        s_d.tck  = (s_d.ph == PH_HIGH);
        s_d.oe   = (s_d.ph != PH_IDLE) && !s_d.pulse[1];
        s_d.dout = s_d.oe && (s_d.pulse[0] ? s_d.bit_ms : s_d.bit_di);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, pulse: 2'd0, bit_di: 1'b0, bit_ms: 1'b0,
                     tck: 1'b0, oe: 1'b0, dout: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.ph == PH_IDLE);
    assign done      = s_q.done;
    assign tck_o     = s_q.tck;
    assign tdat_o    = s_q.dout;
    assign tdat_oe   = s_q.oe;
endmodule

// File: rtl/jtag2w_chk.sv
module jtag2w_chk #(
    parameter int HI_CYC     = 4,
    parameter int LO_CYC     = 6,
    parameter int SETTLE_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic tck_o,
    input logic tdat_o,
    input logic tdat_oe,
    input logic tgt_rst_req,
    input logic tgt_rst_n
);
    localparam int RUN_W = $clog2(HI_CYC + 2);

    logic [RUN_W-1:0] hi_run;
    logic [2:0]       fall_cnt;
    logic             tck_prev;
    logic             out_of_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run     <= '0;
            fall_cnt   <= 3'd0;
            tck_prev   <= 1'b0;
            out_of_rst <= 1'b0;
        end else begin
            out_of_rst <= 1'b1;
            tck_prev   <= tck_o;
            hi_run     <= tck_o ? hi_run + 1'b1 : '0;
            if (req_valid && req_ready)      fall_cnt <= 3'd0;
            else if (tck_prev && !tck_o && fall_cnt != 3'd4)
                fall_cnt <= fall_cnt + 3'd1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!tck_o && !tdat_oe));

    // R2
    hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck_o |-> (hi_run < RUN_W'(HI_CYC)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_cnt >= 3'd3) || (fall_cnt == 3'd2 && tck_o)) |-> !tdat_oe);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (tck_o && !req_ready));

    // R9
    tgt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_rst |-> (tgt_rst_n == !$past(tgt_rst_req)));

    // R10
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tdat_oe |-> !tdat_o);
endmodule

bind twowire_jtag_host jtag2w_chk #(
    .HI_CYC     (HI_CYC),
    .LO_CYC     (LO_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .tck_o       (tck_o),
    .tdat_o      (tdat_o),
    .tdat_oe     (tdat_oe),
    .tgt_rst_req (tgt_rst_req),
    .tgt_rst_n   (tgt_rst_n)
);

// File: tb/sim_twowire_jtag_host.sv
`timescale 1ns/1ps
module sim_twowire_jtag_host;
    localparam int CLK_NS = 10;
    localparam int HI     = 2;
    localparam int LO     = 3;
    localparam int SET    = 1;
    localparam int STEP   = 4 * (HI + LO);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_tdi = 1'b0, req_tms = 1'b0;
    logic req_ready, done, done_tdo, tck_o, tdat_o, tdat_oe;
    logic tdat_i = 1'b0;
    logic tgt_rst_req = 1'b0;
    logic tgt_rst_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic exp_di = 1'b0, exp_ms = 1'b0, exp_do = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    twowire_jtag_host #(.HI_CYC(HI), .LO_CYC(LO), .SETTLE_CYC(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tdi(req_tdi),
        .req_tms(req_tms), .req_ready(req_ready), .done(done),
        .done_tdo(done_tdo), .tck_o(tck_o), .tdat_o(tdat_o),
        .tdat_oe(tdat_oe), .tdat_i(tdat_i), .tgt_rst_req(tgt_rst_req),
        .tgt_rst_n(tgt_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // target model: observes the wire at the falling system-clock edge
    logic prev_tck = 1'b0;
    logic hi_val = 1'b0, hi_oe = 1'b0;
    int   falls = 0, hi_len = 0, lo_len = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_tck = 1'b0; falls = 0; hi_len = 0; lo_len = 0;
            tdat_i = 1'b0;
        end else begin
            if (tck_o && !prev_tck) begin
                if (falls == 4) falls = 0;
                if (falls > 0) check(lo_len == LO, "R2 low length", lo_len, LO);
                hi_len = 0;
            end
            if (!tck_o && prev_tck) begin
                check(hi_len == HI, "R2 high length", hi_len, HI);
                falls = falls + 1;
                lo_len = 0;
                if (falls == 1) check(hi_oe && hi_val == exp_di, "R3 data-in at fall", {hi_oe, hi_val}, {1'b1, exp_di});
                if (falls == 2) check(hi_oe && hi_val == exp_ms, "R4 mode-select at fall", {hi_oe, hi_val}, {1'b1, exp_ms});
            end
            if (tck_o) begin
                hi_len = hi_len + 1;
                hi_val = tdat_o;
                hi_oe  = tdat_oe;
                if (falls == 0) check(tdat_oe && tdat_o == exp_di, "R3 data-in held", {tdat_oe, tdat_o}, {1'b1, exp_di});
                if (falls == 1) check(tdat_oe && tdat_o == exp_ms, "R4 mode-select held", {tdat_oe, tdat_o}, {1'b1, exp_ms});
            end else begin
                if (falls == 1 && lo_len >= 0 && !req_ready)
                    check(tdat_oe && tdat_o == exp_di, "R3 data-in in low half", {tdat_oe, tdat_o}, {1'b1, exp_di});
                lo_len = lo_len + 1;
            end
            if (falls >= 3 || (falls == 2 && tck_o))
                check(!tdat_oe, "R5 released", tdat_oe, 0);
            if (!tdat_oe) check(!tdat_o, "R10 quiet data", tdat_o, 0);
            if (falls == 3 && !tck_o)
                tdat_i = (lo_len - 1 == SET) ? exp_do : ~exp_do;
            else
                tdat_i = ~exp_do;
            prev_tck = tck_o;
        end
    end

    task automatic run_step(input logic di, input logic ms, input logic dout, input bit poke);
        int n;
        @(negedge clk);
        exp_di = di; exp_ms = ms; exp_do = dout;
        check(req_ready, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_tdi = di; req_tms = ms;
        @(negedge clk);
        if (poke) begin
            req_tdi = ~di; req_tms = ~ms;
        end else begin
            req_valid = 1'b0;
        end
        n = 1;
        while (!done && n < 200) begin
            check(!req_ready, "R8 busy not ready", req_ready, 0);
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check(n == STEP + 1, "R7 done timing", n, STEP + 1);
        check(done_tdo == dout, "R6 returned bit", done_tdo, dout);
        check(req_ready, "R7 ready with done", req_ready, 1);
        @(negedge clk);
        check(!done, "R7 done single cycle", done, 0);
        check(!tck_o && !tdat_oe, "R1 idle after step", {tck_o, tdat_oe}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!tck_o && !tdat_oe && req_ready && !done, "R1 reset state",
              {tck_o, tdat_oe, req_ready, done}, 4'b0010);
        check(!tgt_rst_n, "R9 reset held in reset", tgt_rst_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(tgt_rst_n, "R9 released", tgt_rst_n, 1);
        tgt_rst_req = 1'b1;
        @(negedge clk);
        check(!tgt_rst_n, "R9 asserted", tgt_rst_n, 0);
        tgt_rst_req = 1'b0;
        @(negedge clk);
        check(tgt_rst_n, "R9 deasserted", tgt_rst_n, 1);
        for (int k = 0; k < 8; k++)
            run_step(k[0], k[1], k[2], 1'b0);
        for (int k = 0; k < 8; k++)
            run_step(k[2], k[0], k[1], 1'b1);
        repeat (5) begin
            @(negedge clk);
            check(!tck_o && !tdat_oe && !done, "R8 no extra step", {tck_o, tdat_oe, done}, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule